// File: doc/BRIEF.md
# Serial PCM Audio Input Receiver

This block receives serial PCM audio on several data pins that share one bit clock and one frame clock. Both clocks and the data pins are sampled by a much faster system clock through two-flop synchronisers; a rising edge of the synchronised, polarity-corrected bit clock marks a sample event. At each sample event the frame clock level chooses the channel, a change in its level marks a channel boundary, and a bit counter places each incoming bit into an MSB-aligned word for every data pin.

A small state machine tracks the frame. `ST_HUNT` is entered at reset and throws away partial channels. The arc `HUNT_TO_LEFT` is taken at the first boundary into the left channel. `LEFT_TO_RIGHT` is taken at the next boundary and latches the left words. `RIGHT_TO_LEFT` publishes the left and right words of every pin together with a one-cycle valid strobe, and then begins the next left word. A boundary into the right channel while in `ST_HUNT` keeps the machine in `ST_HUNT`. The framing is chosen at runtime: I2S, where the MSB follows the frame clock change by one bit slot, or left-justified, where the MSB comes in the first slot. The bit clock edge, the frame clock sense and the word width are also chosen at runtime.

Top module: `pcm_serial_rx`

## Requirements
- R1: While and after reset, `smp_valid` is 0 and `left_out` and `right_out` are all zero until the first frame is published.
- R2: With `cfg_sclk_inv`=0 the data is sampled on the rising edge of `sclk_in`. With `cfg_sclk_inv`=1 it is sampled on the falling edge.
- R3: With `cfg_lrclk_inv`=0 the left channel is received while `lrclk_in` is low and the right channel while it is high. With `cfg_lrclk_inv`=1 these levels are swapped.
- R4: With `cfg_lj`=0 (I2S), the MSB of a word is in the second bit slot after the frame clock change. The first slot after a change carries the last bit of the word before it.
- R5: With `cfg_lj`=1 (left-justified), the MSB of a word is in the first bit slot after the frame clock change.
- R6: Each output word is MAX_W bits and MSB-aligned: the k-th received bit, counting from 0, goes to bit MAX_W-1-k. Only the first `cfg_width` bits of a channel are kept (a value of 0 or above MAX_W means MAX_W). Later bits are ignored, and bits below the width read as zero.
- R7: A channel with fewer bit slots than `cfg_width` gives a word whose missing low bits are zero.
- R8: `smp_valid` is high for exactly one system cycle, at the boundary that ends a right channel. In that same cycle `left_out` and `right_out` carry the pair of every pin, and they hold their values until the next pulse.
- R9: After reset no pulse is produced until one complete left channel and the right channel after it have been received. Channels cut short by reset are discarded.
- R10: Each data pin has its own words in lane slice `[i*MAX_W +: MAX_W]` of the outputs, independently of the other pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_lj | input | 1 | 0 = I2S framing, 1 = left-justified framing |
| cfg_sclk_inv | input | 1 | 1 = sample data on the falling bit clock edge |
| cfg_lrclk_inv | input | 1 | 1 = left channel while the frame clock is high |
| cfg_width | input | CW | Kept bits per word (0 means MAX_W) |
| sclk_in | input | 1 | Serial bit clock, asynchronous |
| lrclk_in | input | 1 | Frame clock, asynchronous |
| sdata_in | input | LANES | Serial data pins |
| left_out | output | LANES*MAX_W | Left words, one MAX_W slice per pin |
| right_out | output | LANES*MAX_W | Right words, one MAX_W slice per pin |
| smp_valid | output | 1 | One-cycle strobe when a new pair is published |

## Verification
The hardest case is the I2S boundary slot. In that single sample event the bit must finish the old channel at its last position while the machine closes that channel, moves to the other one and clears the accumulator. If the order is wrong, the LSB lands in the wrong word. The bench reaches this slot by driving full 32-slot channels with a width of 32, where the carried bit is kept. It also drives 20-slot channels, where the carried bit is the last valid bit before the zero padding. Each scenario starts with a partial left channel and a full right channel of filler data, so the bench also checks that `ST_HUNT` discards both.

// File: rtl/pcm_rx_pkg.sv
package pcm_rx_pkg;
    typedef enum logic [1:0] {
        ST_HUNT  = 2'd0,
        ST_LEFT  = 2'd1,
        ST_RIGHT = 2'd2
    } rx_state_e;
endpackage

// File: rtl/pcm_sync2.sv
module pcm_sync2 #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_in,
    output logic [N-1:0] sync_out
);
    logic [N-1:0] meta_q;
    logic [N-1:0] sync_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= async_in;
            sync_q <= meta_q;
        end
    end

    assign sync_out = sync_q;
endmodule

// File: rtl/pcm_frame_fsm.sv
module pcm_frame_fsm
    import pcm_rx_pkg::*;
#(
    parameter int MAX_W = 32,
    localparam int CW = $clog2(MAX_W + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sample_ev,
    input  logic          lr_eff,
    input  logic          fmt_lj,
    input  logic [CW-1:0] w_eff,
    output logic [CW-1:0] bit_idx,
    output logic          put_old,
    output logic          put_new,
    output logic          close,
    output logic          to_left,
    output logic          to_right,
    output logic          frame_valid
);
    rx_state_e     state, state_nxt;
    logic          lr_prev;
    logic [CW-1:0] cnt;
    logic          valid_q;
    logic          boundary;

    assign boundary = sample_ev && (lr_eff != lr_prev);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_HUNT;
        else        state <= state_nxt;
    end

    // next state
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_HUNT:  if (boundary && !lr_eff) state_nxt = ST_LEFT;
            ST_LEFT:  if (boundary)            state_nxt = ST_RIGHT;
            ST_RIGHT: if (boundary)            state_nxt = ST_LEFT;
            default:                           state_nxt = ST_HUNT;
        endcase
    end

    // per-event outputs to the lanes
    always_comb begin
        bit_idx  = cnt;
        put_old  = sample_ev && !(boundary && fmt_lj) && (cnt < w_eff);
        put_new  = boundary && fmt_lj;
        close    = boundary && ((state != ST_HUNT) || !lr_eff);
        to_left  = close && (state == ST_LEFT);
        to_right = close && (state == ST_RIGHT);
    end

    // bit counter, frame clock history, strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lr_prev <= 1'b0;
            cnt     <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= to_right;
            if (sample_ev) begin
                lr_prev <= lr_eff;
                if (boundary)
                    cnt <= fmt_lj ? CW'(1) : '0;
                else if (cnt != CW'(MAX_W))
                    cnt <= cnt + CW'(1);
            end
        end
    end

    assign frame_valid = valid_q;

    // R8
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |=> !valid_q);
    // R8
    pulse_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |-> (state == ST_LEFT));
    // R9
    hunt_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HUNT) |=> (state != ST_RIGHT));
    // R9
    hunt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HUNT) |=> !valid_q);
endmodule

// File: rtl/pcm_lane_word.sv
module pcm_lane_word #(
    parameter int MAX_W = 32,
    localparam int CW = $clog2(MAX_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_in,
    input  logic [CW-1:0]    bit_idx,
    input  logic             put_old,
    input  logic             put_new,
    input  logic             close,
    input  logic             to_left,
    input  logic             to_right,
    input  logic [MAX_W-1:0] lo_mask,
    output logic [MAX_W-1:0] left_word,
    output logic [MAX_W-1:0] right_word
);
    localparam logic [MAX_W-1:0] MSB_ONE = {1'b1, {(MAX_W-1){1'b0}}};

    logic [MAX_W-1:0] acc, l_hold, l_q, r_q;
    logic [MAX_W-1:0] word_wr;

    always_comb begin
        word_wr = acc;
        if (put_old && bit_in)
            word_wr = acc | (MSB_ONE >> bit_idx);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc    <= '0;
            l_hold <= '0;
            l_q    <= '0;
            r_q    <= '0;
        end else if (close) begin
            if (to_left)
                l_hold <= word_wr;
            if (to_right) begin
                r_q <= word_wr;
                l_q <= l_hold;
            end
            acc <= (put_new && bit_in) ? MSB_ONE : '0;
        end else if (put_old) begin
            acc <= word_wr;
        end
    end

    assign left_word  = l_q;
    assign right_word = r_q;

    // R6
    width_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        to_right |=> ((r_q & lo_mask) == '0) && ((l_q & lo_mask) == '0));
    // R8
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !to_right |=> $stable(r_q) && $stable(l_q));
endmodule

// File: rtl/pcm_serial_rx.sv
module pcm_serial_rx #(
    parameter int LANES = 2,
    parameter int MAX_W = 32,
    localparam int CW = $clog2(MAX_W + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_lj,
    input  logic                   cfg_sclk_inv,
    input  logic                   cfg_lrclk_inv,
    input  logic [CW-1:0]          cfg_width,
    input  logic                   sclk_in,
    input  logic                   lrclk_in,
    input  logic [LANES-1:0]       sdata_in,
    output logic [LANES*MAX_W-1:0] left_out,
    output logic [LANES*MAX_W-1:0] right_out,
    output logic                   smp_valid
);
    localparam int NS = LANES + 2;

    logic [NS-1:0]    sync_v;
    logic             sclk_eff, sclk_prev, sample_ev, lr_eff;
    logic [LANES-1:0] data_s;
    logic [CW-1:0]    w_eff;
    logic [MAX_W-1:0] lo_mask;
    logic [CW-1:0]    bit_idx;
    logic             put_old, put_new, close, to_left, to_right;

    pcm_sync2 #(.N(NS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({sdata_in, lrclk_in, sclk_in}),
        .sync_out (sync_v)
    );

    assign sclk_eff = sync_v[0] ^ cfg_sclk_inv;
    assign lr_eff   = sync_v[1] ^ cfg_lrclk_inv;
    assign data_s   = sync_v[NS-1:2];

    always_ff @(posedge clk) begin
        if (!rst_n) sclk_prev <= 1'b1;
        else        sclk_prev <= sclk_eff;
    end

    assign sample_ev = sclk_eff && !sclk_prev;

    assign w_eff   = ((cfg_width == '0) || (cfg_width > CW'(MAX_W))) ? CW'(MAX_W) : cfg_width;
    assign lo_mask = {MAX_W{1'b1}} >> w_eff;

    pcm_frame_fsm #(.MAX_W(MAX_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .sample_ev   (sample_ev),
        .lr_eff      (lr_eff),
        .fmt_lj      (cfg_lj),
        .w_eff       (w_eff),
        .bit_idx     (bit_idx),
        .put_old     (put_old),
        .put_new     (put_new),
        .close       (close),
        .to_left     (to_left),
        .to_right    (to_right),
        .frame_valid (smp_valid)
    );

    // R10: one word assembler per data pin
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        pcm_lane_word #(.MAX_W(MAX_W)) u_lane (
            .clk        (clk),
            .rst_n      (rst_n),
            .bit_in     (data_s[i]),
            .bit_idx    (bit_idx),
            .put_old    (put_old),
            .put_new    (put_new),
            .close      (close),
            .to_left    (to_left),
            .to_right   (to_right),
            .lo_mask    (lo_mask),
            .left_word  (left_out[i*MAX_W +: MAX_W]),
            .right_word (right_out[i*MAX_W +: MAX_W])
        );
    end

    // R2
    sample_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_ev |=> !sample_ev);
endmodule

// File: tb/test_pcm_serial_rx.sv
module test_pcm_serial_rx;
    localparam int LANES = 2;
    localparam int MAX_W = 32;
    localparam int CW    = $clog2(MAX_W + 1);

    typedef struct packed {
        logic [LANES*MAX_W-1:0] l;
        logic [LANES*MAX_W-1:0] r;
    } exp_t;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   cfg_lj = 1'b0, cfg_sclk_inv = 1'b0, cfg_lrclk_inv = 1'b0;
    logic [CW-1:0]          cfg_width = CW'(32);
    logic                   sclk_in = 1'b0, lrclk_in = 1'b0;
    logic [LANES-1:0]       sdata_in = '0;
    logic [LANES*MAX_W-1:0] left_out, right_out;
    logic                   smp_valid;

    int    n_chk = 0, n_fail = 0;
    exp_t  sb_q[$];
    logic [LANES-1:0] carry_b = '0;
    logic [31:0] seed = 32'h1234_5678;
    bit    done = 1'b0;
    int    cur_width = 32;

    always #2.5 clk = ~clk;

    pcm_serial_rx #(.LANES(LANES), .MAX_W(MAX_W)) i_pcm_serial_rx (
        .clk(clk), .rst_n(rst_n), .cfg_lj(cfg_lj), .cfg_sclk_inv(cfg_sclk_inv),
        .cfg_lrclk_inv(cfg_lrclk_inv), .cfg_width(cfg_width), .sclk_in(sclk_in),
        .lrclk_in(lrclk_in), .sdata_in(sdata_in), .left_out(left_out),
        .right_out(right_out), .smp_valid(smp_valid)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] top_mask(input int n);
        if (n <= 0) return 32'h0;
        return ~(32'hFFFF_FFFF >> n);
    endfunction

    function automatic logic [31:0] next_rand();
        seed = seed * 32'd1103515245 + 32'd12345;
        return seed ^ (seed >> 13);
    endfunction

    // one bit slot: data changes while the effective clock is low
    task automatic drive_slot(input logic lr, input logic [LANES-1:0] bits);
        @(negedge clk);
        sclk_in  = cfg_sclk_inv;
        lrclk_in = lr ^ cfg_lrclk_inv;
        sdata_in = bits;
        repeat (3) @(negedge clk);
        sclk_in = ~cfg_sclk_inv;
        repeat (4) @(negedge clk);
    endtask

    // lr = 0 is left (R3); I2S shifts the word one slot late (R4), LJ does not (R5)
    task automatic send_channel(input logic lr, input logic [LANES*32-1:0] w, input int slots);
        logic [LANES-1:0] last = '0;
        for (int k = 0; k < slots; k++) begin
            logic [LANES-1:0] b;
            for (int i = 0; i < LANES; i++) begin
                if (cfg_lj) b[i] = w[i*32 + 31 - k];
                else        b[i] = (k == 0) ? carry_b[i] : w[i*32 + 31 - (k - 1)];
                last[i] = w[i*32 + 31 - k];
            end
            drive_slot(lr, b);
        end
        carry_b = last;
    endtask

    // driver: pushes the expected pair, then sends the frame
    task automatic send_frame(input int slots);
        logic [LANES*32-1:0] lw, rw;
        exp_t e;
        int n;
        n = (slots < cur_width) ? slots : cur_width;
        for (int i = 0; i < LANES; i++) begin
            lw[i*32 +: 32] = next_rand();
            rw[i*32 +: 32] = next_rand();
            e.l[i*32 +: 32] = lw[i*32 +: 32] & top_mask(n);
            e.r[i*32 +: 32] = rw[i*32 +: 32] & top_mask(n);
        end
        sb_q.push_back(e);
        send_channel(1'b0, lw, slots);
        send_channel(1'b1, rw, slots);
    endtask

    task automatic scenario(input logic lj, input logic sinv, input logic linv,
                            input int width, input int slots, input int frames);
        rst_n = 1'b0;
        cfg_lj = lj; cfg_sclk_inv = sinv; cfg_lrclk_inv = linv;
        cfg_width = CW'(width);
        cur_width = (width == 0 || width > 32) ? 32 : width;
        sclk_in = sinv; lrclk_in = linv; sdata_in = '0; carry_b = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R1
        check(smp_valid == 1'b0, "R1 valid after reset", {63'd0, smp_valid}, 64'd0);
        check(left_out == '0 && right_out == '0, "R1 outputs after reset", left_out, 64'd0);
        // R9: partial left and full right of filler must be discarded
        send_channel(1'b0, {next_rand(), next_rand()}, 5);
        send_channel(1'b1, {next_rand(), next_rand()}, slots);
        for (int f = 0; f < frames; f++) send_frame(slots);
        send_channel(1'b0, '0, 2);
        repeat (12) @(negedge clk);
        // R9/R8: one pulse per complete frame, none extra
        check(sb_q.size() == 0, "R9 pulse count", 64'(sb_q.size()), 64'd0);
        sb_q.delete();
    endtask

    // monitor: pops the scoreboard on each strobe
    logic                   prev_v = 1'b0;
    logic [LANES*MAX_W-1:0] hold_l = '0, hold_r = '0;
    always @(negedge clk) begin
        if (!rst_n) begin
            prev_v <= 1'b0;
            hold_l <= '0;
            hold_r <= '0;
        end else begin
            if (smp_valid) begin
                // R8
                check(!prev_v, "R8 single-cycle strobe", 64'd1, 64'd0);
                if (sb_q.size() == 0) begin
                    check(1'b0, "R9 strobe with no frame sent", 64'd1, 64'd0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    for (int i = 0; i < LANES; i++) begin
                        // R4 R5 R6 R7 R10
                        check(left_out[i*32 +: 32] == e.l[i*32 +: 32], "R6/R10 left word",
                              64'(left_out[i*32 +: 32]), 64'(e.l[i*32 +: 32]));
                        check(right_out[i*32 +: 32] == e.r[i*32 +: 32], "R6/R10 right word",
                              64'(right_out[i*32 +: 32]), 64'(e.r[i*32 +: 32]));
                    end
                end
                hold_l <= left_out;
                hold_r <= right_out;
            end else if (left_out != hold_l || right_out != hold_r) begin
                // R8: outputs hold between strobes
                check(1'b0, "R8 hold between strobes", left_out, hold_l);
            end
            prev_v <= smp_valid;
        end
    end

    initial begin
        // R4 I2S, normal polarity, 32 slots, width 24: extra bits ignored (R6)
        scenario(1'b0, 1'b0, 1'b0, 24, 32, 4);
        // R4 I2S, full width: the carried LSB is kept
        scenario(1'b0, 1'b0, 1'b0, 32, 32, 3);
        // R5 left-justified, width 0 treated as 32
        scenario(1'b1, 1'b0, 1'b0, 0, 32, 3);
        // R2 R3 both polarities inverted, LJ, width 16 in 24 slots
        scenario(1'b1, 1'b1, 1'b1, 16, 24, 4);
        // R2 R7 I2S, falling edge sampling, short 20-slot channels in width 32
        scenario(1'b0, 1'b1, 1'b0, 32, 20, 4);
        // R3 R7 LJ, inverted frame clock only, width 24 in 16 slots
        scenario(1'b1, 1'b0, 1'b1, 24, 16, 3);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule